// File: doc/BRIEF.md
# Shared Memory Port Arbiter for Fetch and Data Access

This block sits between the two memory users of an in-order five-stage pipeline and a single memory port that can carry only one access per clock. The fetch stage offers an instruction address every cycle. The memory stage may offer a load or a store in the same cycle. The arbiter chooses which of the two uses the port, drives the port, and steers the returned word back to whichever side asked for it.

The memory reads synchronously: an access issued in cycle t returns its word in cycle t+1. When both sides request in the same cycle, the data access always gets the port and `fetch_stall` rises in that cycle. The program counter holds its value, and the same fetch address is presented again on the next cycle. In the cycle after a stalled fetch, decode receives an all-zero word, which is the no-operation encoding. One bubble therefore enters the pipeline for every conflict cycle.

The memory is word-organised. The byte address is shifted down by the word-offset bits to form the port address.

Top module: `shared_port_arbiter`

## Requirements
- R1: With a fetch request and no data request, the port performs a read (`mem_en`=1, `mem_we`=0) at `mem_addr` = fetch byte address shifted right by 2, and `fetch_stall` stays 0.
- R2: With a data request and no fetch request, the port carries the data word address (byte address shifted right by 2), `mem_we` equal to the data write flag, and the write data.
- R3: When fetch and data requests arrive in the same cycle, the data access drives the port and `fetch_stall` is 1 in that cycle.
- R4: A store (`data_we`=1) conflicts with a fetch in exactly the same way as a load: the port writes and the fetch stalls.
- R5: One cycle after a granted fetch, `fetch_valid` is 1 and `fetch_instr` equals the memory word at the fetched address.
- R6: One cycle after a stalled fetch (or a cycle with no fetch request), `fetch_valid` is 0 and `fetch_instr` is 32'h0000_0000. Exactly one such bubble follows each conflict cycle.
- R7: One cycle after a granted load, `load_valid` is 1 and `load_data` equals the memory word at the load address. After a store or no data access, `load_valid` is 0 and `load_data` is 0.
- R8: With no request on either side, `mem_en` is 0 and `fetch_stall` is 0.
- R9: While reset is held, `fetch_valid` and `load_valid` are 0 and `fetch_instr` is the all-zero no-operation word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch stage wants an instruction this cycle |
| fetch_addr | input | 32 | Byte address of the instruction |
| data_req | input | 1 | Memory stage wants a load or store this cycle |
| data_we | input | 1 | 1 for a store, 0 for a load |
| data_addr | input | 32 | Byte address of the data access |
| data_wdata | input | 32 | Store data |
| mem_en | output | 1 | Port access enable |
| mem_we | output | 1 | Port write enable |
| mem_addr | output | 30 | Port word address |
| mem_wdata | output | 32 | Port write data |
| mem_rdata | input | 32 | Port read data, valid the cycle after a read |
| fetch_stall | output | 1 | Fetch lost the port this cycle; hold the program counter |
| fetch_instr | output | 32 | Instruction for decode, zero when no fetch was served |
| fetch_valid | output | 1 | `fetch_instr` holds a fetched word |
| load_data | output | 32 | Loaded word, zero when no load was served |
| load_valid | output | 1 | `load_data` holds a loaded word |

## Verification
The two functions that can fall in the same cycle are the instruction fetch and the load or store from the memory stage. The bench provokes this in two ways. It places a load and then a store directly beside a fetch, and it runs a long stretch in which the fetch side requests every cycle while data requests arrive at random. Each conflict is judged on three things: the port carries the data side's address and write flag, the stall is raised in that cycle, and the next cycle hands decode a zero word. The bench also checks that the count of bubbles equals the count of conflicts, and that the frozen fetch address is served correctly on its retry.

// File: rtl/umpa_pkg.sv
package umpa_pkg;

    typedef enum logic [1:0] {
        OWNER_NONE  = 2'd0,
        OWNER_FETCH = 2'd1,
        OWNER_DATA  = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   is_write;
        logic   fetch_held;
    } grant_t;

    function automatic int unsigned offset_bits(input int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

    function automatic logic carries_read(input grant_t g);
        return (g.owner != OWNER_NONE) && !g.is_write;
    endfunction

endpackage

// File: rtl/umpa_grant.sv
module umpa_grant
    import umpa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fetch_req,
    input  logic   data_req,
    input  logic   data_we,
    output grant_t grant
);

    always_comb begin
        grant = '{owner: OWNER_NONE, is_write: 1'b0, fetch_held: 1'b0};
        if (data_req) begin
            grant.owner      = OWNER_DATA;
            grant.is_write   = data_we;
            grant.fetch_held = fetch_req;
        end else if (fetch_req) begin
            grant.owner = OWNER_FETCH;
        end
    end

    p_data_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && data_req) |-> (grant.owner == OWNER_DATA && grant.fetch_held));

    p_store_conflict_r4: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && data_req && data_we) |-> (grant.is_write && grant.fetch_held));

endmodule

// File: rtl/umpa_port_mux.sv
module umpa_port_mux
    import umpa_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int WORD_AW = ADDR_W - offset_bits(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  grant_t             grant,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic [ADDR_W-1:0]  data_addr,
    input  logic [DATA_W-1:0]  data_wdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WORD_AW-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata
);

    localparam int OFFSET_W = offset_bits(DATA_W);

    logic [ADDR_W-1:0] sel_addr;

    always_comb begin
        unique case (grant.owner)
            OWNER_DATA:  sel_addr = data_addr;
            OWNER_FETCH: sel_addr = fetch_addr;
            default:     sel_addr = '0;
        endcase
    end

    assign mem_en    = (grant.owner != OWNER_NONE);
    assign mem_we    = (grant.owner == OWNER_DATA) && grant.is_write;
    assign mem_addr  = WORD_AW'(sel_addr >> OFFSET_W);
    assign mem_wdata = (grant.owner == OWNER_DATA) ? data_wdata : '0;

    p_write_only_data_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_en && grant.owner == OWNER_DATA));

endmodule

// File: rtl/umpa_resp.sv
module umpa_resp
    import umpa_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [DATA_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  grant_t            grant,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] fetch_instr,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] load_data,
    output logic              load_valid
);

    logic fetch_q;
    logic load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= 1'b0;
            load_q  <= 1'b0;
        end else begin
            fetch_q <= (grant.owner == OWNER_FETCH);
            load_q  <= (grant.owner == OWNER_DATA) && carries_read(grant);
        end
    end

    assign fetch_valid = fetch_q;
    assign fetch_instr = fetch_q ? mem_rdata : NOP_WORD;
    assign load_valid  = load_q;
    assign load_data   = load_q ? mem_rdata : '0;

    p_bubble_nop_r6: assert property (@(posedge clk) disable iff (rst)
        grant.fetch_held |=> (!fetch_valid && fetch_instr == NOP_WORD));

    p_one_reader_r7: assert property (@(posedge clk) disable iff (rst)
        !(fetch_valid && load_valid));

endmodule

// File: rtl/shared_port_arbiter.sv
module shared_port_arbiter
    import umpa_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int WORD_AW = ADDR_W - offset_bits(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               data_req,
    input  logic               data_we,
    input  logic [ADDR_W-1:0]  data_addr,
    input  logic [DATA_W-1:0]  data_wdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WORD_AW-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               fetch_stall,
    output logic [DATA_W-1:0]  fetch_instr,
    output logic               fetch_valid,
    output logic [DATA_W-1:0]  load_data,
    output logic               load_valid
);

    grant_t grant;

    umpa_grant u_grant (
        .clk       (clk),
        .rst       (rst),
        .fetch_req (fetch_req),
        .data_req  (data_req),
        .data_we   (data_we),
        .grant     (grant)
    );

    umpa_port_mux #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WORD_AW (WORD_AW)
    ) u_port (
        .clk        (clk),
        .rst        (rst),
        .grant      (grant),
        .fetch_addr (fetch_addr),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    umpa_resp #(
        .DATA_W   (DATA_W),
        .NOP_WORD ('0)
    ) u_resp (
        .clk         (clk),
        .rst         (rst),
        .grant       (grant),
        .mem_rdata   (mem_rdata),
        .fetch_instr (fetch_instr),
        .fetch_valid (fetch_valid),
        .load_data   (load_data),
        .load_valid  (load_valid)
    );

    assign fetch_stall = grant.fetch_held;

    p_fetch_alone_r1: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !data_req) |-> (mem_en && !mem_we && !fetch_stall));

    p_fetch_returns_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !data_req) |=> fetch_valid);

    p_load_returns_r7: assert property (@(posedge clk) disable iff (rst)
        (data_req && !data_we) |=> (load_valid && !fetch_valid));

    p_idle_port_r8: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req && !data_req) |-> (!mem_en && !fetch_stall));

    p_stall_port_r3: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> (mem_en && mem_we == data_we));

endmodule

// File: tb/shared_port_arbiter_tb.sv
module shared_port_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        data_req = 1'b0;
    logic        data_we = 1'b0;
    logic [31:0] data_addr = '0;
    logic [31:0] data_wdata = '0;
    logic        mem_en, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        fetch_stall;
    logic [31:0] fetch_instr;
    logic        fetch_valid;
    logic [31:0] load_data;
    logic        load_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem_arr [256];

    always #4 clk = ~clk;

    shared_port_arbiter u_dut (
        .clk(clk), .rst(rst),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .data_req(data_req), .data_we(data_we),
        .data_addr(data_addr), .data_wdata(data_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fetch_stall(fetch_stall), .fetch_instr(fetch_instr),
        .fetch_valid(fetch_valid), .load_data(load_data),
        .load_valid(load_valid)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr[7:0]];
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check port side, then check responses after the edge.
    task automatic step(input logic fr, input logic [31:0] fa, input logic dr,
                        input logic dw, input logic [31:0] da, input logic [31:0] wd,
                        output logic stalled);
        logic        e_en, e_we, e_stall, e_fv, e_lv;
        logic [29:0] e_addr;
        logic [31:0] e_word;
        fetch_req = fr; fetch_addr = fa; data_req = dr; data_we = dw;
        data_addr = da; data_wdata = wd;
        #1;
        e_en    = fr | dr;
        e_we    = dr & dw;
        e_stall = fr & dr;
        e_addr  = dr ? da[31:2] : (fr ? fa[31:2] : 30'd0);
        e_fv    = fr & ~dr;
        e_lv    = dr & ~dw;
        e_word  = mem_arr[e_addr[7:0]];
        stalled = e_stall;
        if (!fr && !dr)
            chk(mem_en == 1'b0 && fetch_stall == 1'b0, "R8 idle port", {31'd0, mem_en}, 32'd0);
        else if (fr && !dr)
            chk(mem_en && !mem_we && mem_addr == e_addr && !fetch_stall,
                "R1 fetch alone", {2'b0, mem_addr}, {2'b0, e_addr});
        else if (!fr && dr)
            chk(mem_en && mem_we == e_we && mem_addr == e_addr && (!dw || mem_wdata == wd),
                "R2 data alone", {2'b0, mem_addr}, {2'b0, e_addr});
        else
            chk(mem_en && mem_we == e_we && mem_addr == e_addr && fetch_stall,
                dw ? "R4 store conflict" : "R3 load conflict",
                {1'b0, fetch_stall, mem_addr}, {1'b0, 1'b1, e_addr});
        @(posedge clk);
        @(negedge clk);
        if (e_fv)
            chk(fetch_valid && fetch_instr == e_word, "R5 fetch data", fetch_instr, e_word);
        else
            chk(!fetch_valid && fetch_instr == 32'd0, "R6 bubble", fetch_instr, 32'd0);
        if (e_lv)
            chk(load_valid && load_data == e_word, "R7 load data", load_data, e_word);
        else
            chk(!load_valid && load_data == 32'd0, "R7 no load", load_data, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic        st;
        logic [31:0] pc;
        int          conflicts;
        int          bubbles;
        for (int i = 0; i < 256; i++) mem_arr[i] = (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!fetch_valid && !load_valid && fetch_instr == 32'd0, "R9 reset state",
            {30'd0, fetch_valid, load_valid}, 32'd0);
        rst = 1'b0;

        step(1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, st);                      // R8
        step(1'b1, 32'h0000_0010, 1'b0, 1'b0, 32'h0, 32'h0, st);              // R1 R5
        step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_0040, 32'h0, st);              // R2 R7
        step(1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_0044, 32'hDEAD_BEEF, st);      // R2 store
        step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_0044, 32'h0, st);              // R7 readback
        step(1'b1, 32'h0000_0020, 1'b1, 1'b0, 32'h0000_0080, 32'h0, st);      // R3
        chk(st == 1'b1, "R3 stall seen", {31'd0, st}, 32'd1);
        step(1'b1, 32'h0000_0020, 1'b0, 1'b0, 32'h0, 32'h0, st);              // R5 retry
        step(1'b1, 32'h0000_0024, 1'b1, 1'b1, 32'h0000_0084, 32'h1234_5678, st); // R4
        step(1'b1, 32'h0000_0024, 1'b0, 1'b0, 32'h0, 32'h0, st);              // R5 retry
        step(1'b1, 32'h0000_0084, 1'b0, 1'b0, 32'h0, 32'h0, st);              // R5 fetch stored word

        pc = 32'h0000_0100;
        conflicts = 0;
        bubbles = 0;
        for (int n = 0; n < 400; n++) begin
            logic dr, dw;
            dr = ($urandom % 3) == 0;
            dw = ($urandom % 2) == 0;
            step(1'b1, pc, dr, dw, {22'd0, 8'($urandom), 2'b00}, $urandom, st);
            if (st) begin
                conflicts++;
                bubbles++;
            end else begin
                pc = pc + 32'd4;
            end
        end
        chk(bubbles == conflicts && conflicts > 0, "R6 bubbles per conflict",
            32'(bubbles), 32'(conflicts));
        chk(pc == 32'h0000_0100 + 32'(4 * (400 - conflicts)), "R3 pc frozen on stall",
            pc, 32'h0000_0100 + 32'(4 * (400 - conflicts)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule